// File: doc/BRIEF.md
# Page-Buffered Flash Write Controller

This controller sits between a CPU write port and a non-volatile array of 512 pages of 64 bytes, mapped at 8000h to FFFFh. CPU byte writes do not reach the array directly. They collect in a 64-byte staging buffer. When every byte slot of that buffer has been written, the controller switches on the array's programming supply. It then asks the array to erase and program the whole page in a single operation. The operation has no fixed duration, so the controller waits for the array to report completion.

Write permission depends on the address and on the operating mode. In normal mode only the low 512-byte data window (8000h to 81FFh) accepts writes. In serial programming mode the whole array accepts writes. A refused write, or a write that arrives while a page operation runs, is discarded and raises a sticky error flag. Software reads this flag and clears it through a small status register.

Top module: `pagewr_ctrl`

## Requirements
- R1: After reset, st_rdata is 00h, arr_pwr_en and arr_pgm_req are low, and arr_wdata is all zero.
- R2: An accepted write stores its byte in slot addr[5:0] of the staging buffer. No array activity starts until all 64 distinct slots hold data. Writing a slot a second time does not count toward filling the buffer.
- R3: The accepted write that fills the last empty slot sets busy and arr_pwr_en in the following cycle, with arr_pgm_req still low. arr_pgm_req rises one cycle later. While it is high, arr_wdata carries slot i on bits [8i+7:8i].
- R4: arr_page equals addr[14:6] of the first write accepted into an empty buffer. Later writes use only addr[5:0]. arr_page stays stable while a request is pending.
- R5: arr_pgm_req stays high until arr_done is seen, however many cycles that takes. In the cycle after arr_done, busy, arr_pwr_en and arr_pgm_req are low and the buffer is empty again.
- R6: With serial_mode=0, only addresses 8000h to 81FFh are accepted. Any other write is discarded without changing the buffer, and the error bit is set.
- R7: With serial_mode=1, addresses 8000h to FFFFh are accepted. A write below 8000h is discarded and the error bit is set.
- R8: A write issued while busy is discarded, leaves arr_wdata unchanged, and sets the error bit.
- R9: st_rdata bit 0 is busy, bit 1 is the sticky error, and all other bits read 0. A status write with bit 1 = 1 clears the error. A status write with bit 1 = 0 leaves it unchanged. A new error in the same cycle as a clear leaves the error set.
- R10: arr_pwr_en is high only while a page operation is in progress, and it is always high while arr_pgm_req is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| serial_mode | input | 1 | 1 = serial programming mode (whole array writable) |
| wr_en | input | 1 | CPU byte write strobe into the array space |
| wr_addr | input | 16 | CPU byte address |
| wr_data | input | 8 | CPU write byte |
| st_we | input | 1 | Status register write strobe |
| st_wdata | input | 8 | Status write data (bit 1 = clear error) |
| st_rdata | output | 8 | Status: bit 0 busy, bit 1 error |
| arr_pwr_en | output | 1 | Programming supply enable toward the array |
| arr_pgm_req | output | 1 | Erase-and-program request, held until done |
| arr_page | output | 9 | Target page number |
| arr_wdata | output | 512 | Staged page contents, slot i on bits [8i+7:8i] |
| arr_done | input | 1 | Array reports the page operation finished |

## Verification
Two events can fall in the same cycle: a status write that clears the error flag, and a fresh error from a refused write. The bench provokes this by driving a status write with bit 1 set in the same clock as a normal-mode write to 8200h, starting from a cleared flag. The flag must read 1 afterwards, so a new fault is never lost to a clear that happens at the same moment. A second overlap is a CPU write made during a page operation. The bench checks that this write raises the flag and that the page image presented to the array does not change.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
  // Bit positions inside the status word seen by software.
  localparam int unsigned ST_BUSY_BIT = 0;
  localparam int unsigned ST_ERR_BIT  = 1;
  localparam int unsigned ST_W        = 8;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_PWRUP = 2'd1,
    SQ_PROG  = 2'd2
  } sq_state_t;
endpackage

// File: rtl/pwc_decode.sv
module pwc_decode #(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned ARR_BASE   = 32'h8000,
  parameter int unsigned ARR_BYTES  = 32768,
  parameter int unsigned DATA_BYTES = 512,
  parameter int unsigned IDX_W      = 6,
  parameter int unsigned PAGE_W     = 9
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              serial_mode,
  output logic              addr_ok,
  output logic [PAGE_W-1:0] page,
  output logic [IDX_W-1:0]  idx
);
  localparam int unsigned OFF_W = IDX_W + PAGE_W;

  // True when address a falls inside [lo, lo+span).
  function automatic logic in_window(input logic [ADDR_W-1:0] a,
                                     input int unsigned lo,
                                     input int unsigned span);
    logic [31:0] a32;
    a32 = 32'(a);
    return (a32 >= lo) && (a32 < lo + span);
  endfunction

  // Write permission: data window always, full array only in serial mode.
  function automatic logic may_write(input logic [ADDR_W-1:0] a, input logic ser);
    return ser ? in_window(a, ARR_BASE, ARR_BYTES)
               : in_window(a, ARR_BASE, DATA_BYTES);
  endfunction

  logic [OFF_W-1:0] off;
  assign off     = OFF_W'(addr - ADDR_W'(ARR_BASE));
  assign addr_ok = may_write(addr, serial_mode);
  assign page    = off[OFF_W-1:IDX_W];
  assign idx     = off[IDX_W-1:0];
endmodule

// File: rtl/pwc_stage_buf.sv
module pwc_stage_buf #(
  parameter int unsigned PAGE_BYTES = 64,
  parameter int unsigned IDX_W      = 6,
  parameter int unsigned PAGE_W     = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr,
  input  logic [IDX_W-1:0]        idx,
  input  logic [PAGE_W-1:0]       page,
  input  logic [7:0]              wdata,
  input  logic                    clr,
  output logic                    completes,
  output logic [PAGE_W-1:0]       page_q,
  output logic [PAGE_BYTES*8-1:0] flat
);
  logic [PAGE_BYTES-1:0] vld_q;
  logic [PAGE_BYTES-1:0] hit;
  logic                  empty;

  assign hit       = wr ? ({{(PAGE_BYTES-1){1'b0}}, 1'b1} << idx) : '0;
  assign empty     = ~|vld_q;
  assign completes = wr && (&(vld_q | hit));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= '0;
      page_q <= '0;
    end else if (clr) begin
      vld_q  <= '0;
    end else if (wr) begin
      vld_q <= vld_q | hit;
      if (empty) page_q <= page;
    end
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    logic [7:0] b_q;
    always_ff @(posedge clk) begin
      if (!rst_n)      b_q <= '0;
      else if (hit[g]) b_q <= wdata;
    end
    assign flat[8*g +: 8] = b_q;
  end
endmodule

// File: rtl/pwc_seq.sv
module pwc_seq
  import pwc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic arr_done,
  output logic pgm_req,
  output logic pwr_en,
  output logic busy,
  output logic done_ev
);
  sq_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SQ_IDLE:  if (start) st_d = SQ_PWRUP;
      SQ_PWRUP: st_d = SQ_PROG;
      SQ_PROG:  if (arr_done) st_d = SQ_IDLE;
      default:  st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= SQ_IDLE;
    else        st_q <= st_d;
  end

  assign pgm_req = (st_q == SQ_PROG);
  assign pwr_en  = (st_q != SQ_IDLE);
  assign busy    = (st_q != SQ_IDLE);
  assign done_ev = (st_q == SQ_PROG) && arr_done;
endmodule

// File: rtl/pwc_status.sv
module pwc_status
  import pwc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_err,
  input  logic            st_we,
  input  logic [ST_W-1:0] st_wdata,
  input  logic            busy,
  output logic            err_q,
  output logic [ST_W-1:0] rdata
);
  logic clr_req;
  logic unused_wbits;

  assign clr_req      = st_we && st_wdata[ST_ERR_BIT];
  assign unused_wbits = ^(st_wdata & ~(ST_W'(1) << ST_ERR_BIT));

  // A new error outranks a clear arriving in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n)       err_q <= 1'b0;
    else if (set_err) err_q <= 1'b1;
    else if (clr_req) err_q <= 1'b0;
  end

  always_comb begin
    rdata              = '0;
    rdata[ST_BUSY_BIT] = busy;
    rdata[ST_ERR_BIT]  = err_q;
  end
endmodule

// File: rtl/pagewr_ctrl.sv
module pagewr_ctrl
  import pwc_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned ARR_BASE   = 32'h8000,
  parameter int unsigned PAGE_BYTES = 64,
  parameter int unsigned NUM_PAGES  = 512,
  parameter int unsigned DATA_BYTES = 512,
  localparam int unsigned IDX_W     = $clog2(PAGE_BYTES),
  localparam int unsigned PAGE_W    = $clog2(NUM_PAGES),
  localparam int unsigned ARR_BYTES = PAGE_BYTES * NUM_PAGES,
  localparam int unsigned BUF_W     = PAGE_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              serial_mode,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              st_we,
  input  logic [ST_W-1:0]   st_wdata,
  output logic [ST_W-1:0]   st_rdata,
  output logic              arr_pwr_en,
  output logic              arr_pgm_req,
  output logic [PAGE_W-1:0] arr_page,
  output logic [BUF_W-1:0]  arr_wdata,
  input  logic              arr_done
);
  logic              addr_ok;
  logic [PAGE_W-1:0] dec_page;
  logic [IDX_W-1:0]  dec_idx;
  logic              busy;
  logic              err;

  // Named internal events, also observed by the bound checker.
  logic ev_accept;
  logic ev_rej_prot;
  logic ev_rej_busy;
  logic ev_start;
  logic ev_done;

  pwc_decode #(
    .ADDR_W(ADDR_W), .ARR_BASE(ARR_BASE), .ARR_BYTES(ARR_BYTES),
    .DATA_BYTES(DATA_BYTES), .IDX_W(IDX_W), .PAGE_W(PAGE_W)
  ) u_dec (
    .addr(wr_addr), .serial_mode(serial_mode),
    .addr_ok(addr_ok), .page(dec_page), .idx(dec_idx)
  );

  assign ev_accept   = wr_en && !busy && addr_ok;
  assign ev_rej_prot = wr_en && !busy && !addr_ok;
  assign ev_rej_busy = wr_en && busy;

  pwc_stage_buf #(
    .PAGE_BYTES(PAGE_BYTES), .IDX_W(IDX_W), .PAGE_W(PAGE_W)
  ) u_buf (
    .clk(clk), .rst_n(rst_n), .wr(ev_accept), .idx(dec_idx),
    .page(dec_page), .wdata(wr_data), .clr(ev_done),
    .completes(ev_start), .page_q(arr_page), .flat(arr_wdata)
  );

  pwc_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(ev_start), .arr_done(arr_done),
    .pgm_req(arr_pgm_req), .pwr_en(arr_pwr_en), .busy(busy), .done_ev(ev_done)
  );

  pwc_status u_st (
    .clk(clk), .rst_n(rst_n), .set_err(ev_rej_prot || ev_rej_busy),
    .st_we(st_we), .st_wdata(st_wdata), .busy(busy),
    .err_q(err), .rdata(st_rdata)
  );
endmodule

// File: rtl/pagewr_ctrl_chk.sv
module pagewr_ctrl_chk #(
  parameter int unsigned PAGE_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              busy,
  input logic              err,
  input logic              ev_start,
  input logic              ev_rej_prot,
  input logic              ev_done,
  input logic              arr_pgm_req,
  input logic              arr_pwr_en,
  input logic              arr_done,
  input logic [PAGE_W-1:0] arr_page
);
  p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> busy && arr_pwr_en && !arr_pgm_req);

  p_req_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> ##1 arr_pgm_req);

  p_page_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    arr_pgm_req && !arr_done |=> $stable(arr_page));

  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    arr_pgm_req && !arr_done |=> arr_pgm_req);

  p_done_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done |=> !busy && !arr_pwr_en && !arr_pgm_req);

  p_prot_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rej_prot |=> err);

  p_busy_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && wr_en |=> err);

  p_pwr_cover_r10: assert property (@(posedge clk) disable iff (!rst_n)
    arr_pgm_req |-> arr_pwr_en);
endmodule

bind pagewr_ctrl pagewr_ctrl_chk #(.PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .busy(busy), .err(err),
  .ev_start(ev_start), .ev_rej_prot(ev_rej_prot), .ev_done(ev_done),
  .arr_pgm_req(arr_pgm_req), .arr_pwr_en(arr_pwr_en),
  .arr_done(arr_done), .arr_page(arr_page)
);

// File: tb/pagewr_ctrl_tb.sv
`timescale 1ns/1ps
module pagewr_ctrl_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         serial_mode = 1'b0;
  logic         wr_en = 1'b0;
  logic [15:0]  wr_addr = '0;
  logic [7:0]   wr_data = '0;
  logic         st_we = 1'b0;
  logic [7:0]   st_wdata = '0;
  logic [7:0]   st_rdata;
  logic         arr_pwr_en;
  logic         arr_pgm_req;
  logic [8:0]   arr_page;
  logic [511:0] arr_wdata;
  logic         arr_done = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  int lat = 3;
  int cnt = 0;

  always #5 clk = ~clk;

  pagewr_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .serial_mode(serial_mode), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .st_we(st_we), .st_wdata(st_wdata),
    .st_rdata(st_rdata), .arr_pwr_en(arr_pwr_en), .arr_pgm_req(arr_pgm_req),
    .arr_page(arr_page), .arr_wdata(arr_wdata), .arr_done(arr_done)
  );

  // Array model: done pulse after a variable number of cycles.
  always @(posedge clk) begin
    if (!rst_n || !arr_pgm_req || arr_done) begin
      cnt <= 0; arr_done <= 1'b0;
    end else if (cnt == lat) arr_done <= 1'b1;
    else cnt <= cnt + 1;
  end

  typedef struct packed { logic ser; logic [15:0] addr; logic exp_err; } vec_t;
  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 16'h8000, 1'b0}, '{1'b0, 16'h81FF, 1'b0}, '{1'b0, 16'h8200, 1'b1},
    '{1'b0, 16'hFFFF, 1'b1}, '{1'b0, 16'h7FFF, 1'b1}, '{1'b1, 16'h8200, 1'b0},
    '{1'b1, 16'hFFFF, 1'b0}, '{1'b1, 16'h7FFF, 1'b1}, '{1'b0, 16'h0000, 1'b1}
  };

  task automatic chk(input string req, input logic [511:0] act, input logic [511:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; serial_mode = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; @(negedge clk);
  endtask

  task automatic cpu_wr(input logic [15:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic st_wr(input logic [7:0] v);
    st_we = 1'b1; st_wdata = v;
    @(negedge clk); st_we = 1'b0;
  endtask

  task automatic wait_done();
    while (!arr_done) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_all();
    logic [511:0] exp_img;
    logic [511:0] held;
    do_reset();
    chk("R1 status", 512'(st_rdata), 512'h00);
    chk("R1 pwr", 512'(arr_pwr_en), 512'h0);
    chk("R1 req", 512'(arr_pgm_req), 512'h0);
    chk("R1 wdata", arr_wdata, 512'h0);

    // Decode table walk (R6 normal mode, R7 serial mode), clearing via R9.
    for (int i = 0; i < NV; i++) begin
      serial_mode = VECS[i].ser;
      cpu_wr(VECS[i].addr, 8'h5A);
      chk(VECS[i].ser ? "R7 region" : "R6 region", 512'(st_rdata[1]), 512'(VECS[i].exp_err));
      st_wr(8'h02);
      chk("R9 clear", 512'(st_rdata[1]), 512'h0);
    end
    do_reset();

    // Normal-mode fill of page 5 with an intruding protected write.
    lat = 3;
    for (int i = 0; i < 10; i++) cpu_wr(16'h8140 + 16'(i), 8'(i) ^ 8'hA5);
    cpu_wr(16'h8200, 8'hEE);
    chk("R6 prot err", 512'(st_rdata), 512'h02);
    st_wr(8'h00);
    chk("R9 no-clear", 512'(st_rdata), 512'h02);
    st_wr(8'h02);
    cpu_wr(16'h8149, 8'd9 ^ 8'hA5);
    for (int i = 10; i < 63; i++) cpu_wr(16'h8140 + 16'(i), 8'(i) ^ 8'hA5);
    chk("R2 not full", 512'(st_rdata), 512'h00);
    chk("R10 pwr idle", 512'(arr_pwr_en), 512'h0);
    cpu_wr(16'h817F, 8'd63 ^ 8'hA5);
    chk("R3 busy", 512'(st_rdata), 512'h01);
    chk("R3 pwr", 512'(arr_pwr_en), 512'h1);
    chk("R3 req low", 512'(arr_pgm_req), 512'h0);
    @(negedge clk);
    for (int i = 0; i < 64; i++) exp_img[8*i +: 8] = 8'(i) ^ 8'hA5;
    chk("R3 req", 512'(arr_pgm_req), 512'h1);
    chk("R4 page", 512'(arr_page), 512'd5);
    chk("R3 image", arr_wdata, exp_img);
    held = arr_wdata;
    cpu_wr(16'h8140, 8'h11);
    chk("R8 busy err", 512'(st_rdata), 512'h03);
    chk("R8 image held", arr_wdata, held);
    wait_done();
    chk("R5 idle", 512'(st_rdata[0]), 512'h0);
    chk("R5 pwr off", 512'(arr_pwr_en), 512'h0);
    chk("R5 req off", 512'(arr_pgm_req), 512'h0);
    st_wr(8'h02);

    // Serial mode: page latched from first write, longer latency.
    serial_mode = 1'b1; lat = 20;
    cpu_wr(16'hFFFF, 8'h3C);
    exp_img[8*63 +: 8] = 8'h3C;
    for (int i = 0; i < 63; i++) begin
      cpu_wr(16'h8000 + 16'(i), 8'(i * 7));
      exp_img[8*i +: 8] = 8'(i * 7);
    end
    chk("R7 busy", 512'(st_rdata), 512'h01);
    @(negedge clk);
    chk("R4 latched page", 512'(arr_page), 512'd511);
    chk("R3 serial image", arr_wdata, exp_img);
    wait_done();
    chk("R5 released", 512'(st_rdata), 512'h00);

    // Clear and new error in the same cycle: set wins.
    serial_mode = 1'b0;
    st_we = 1'b1; st_wdata = 8'h02; wr_en = 1'b1; wr_addr = 16'h8200; wr_data = 8'h77;
    @(negedge clk); st_we = 1'b0; wr_en = 1'b0;
    chk("R9 set wins", 512'(st_rdata), 512'h02);
    st_wr(8'h02);

    // Buffer emptied by completion: one write does not start a program.
    cpu_wr(16'h8000, 8'h01);
    chk("R5 empty", 512'(st_rdata), 512'h00);
    chk("R10 no pwr", 512'(arr_pwr_en), 512'h0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule